// File: doc/BRIEF.md
# Overlapped Translation and Data Lookup Unit

This unit serves word reads and writes from a small direct-mapped data store. The address translation buffer and the data store are both searched in the same clock cycle from one virtual address. This works because the line index is drawn entirely from the untranslated page-offset field of the address. The translation buffer returns a physical page number. That number is compared with the tag held in the indexed line. The comparison decides whether the access completes at once, goes out to memory at the physical address, or stops because the buffer holds no translation for the page.

A translation miss is reported to an external walker through a one-cycle refill request that carries the virtual page number. The walker installs entries through a write port, and the unit overwrites its entries in rotation. After a memory read returns, the line is filled, tagged with the physical page number and marked valid. The unit tracks a referenced bit and a dirty bit for each translation, plus a write-permission bit. A write to a page without write permission is refused.

Top module: `ovl_lookup`

## Requirements
- R1: After reset, `busy`, `resp_valid`, `mem_req_valid` and `tlb_refill_req` are low, and every translation entry is invalid, so the first lookup reports a translation miss.
- R2: A request whose virtual page (address bits 31:12) matches no valid entry produces, one cycle after acceptance, `resp_valid` with `resp_kind` = 2, plus a one-cycle `tlb_refill_req` whose `tlb_refill_vpn` equals that virtual page.
- R3: A read that hits both the translation and the data line responds one cycle after acceptance with `resp_kind` = 0 and the stored word. `resp_flags[1]` (referenced) is set in that response.
- R4: When the translation hits but the line misses, `mem_req_valid` pulses for exactly one cycle, one cycle after acceptance. `mem_req_paddr` equals {physical page, address bits 11:0}. `busy` stays high until the memory response.
- R5: On `mem_resp_valid`, the line selected by address bits 11:2 is filled with the physical page as its tag and marked valid. The next cycle carries `resp_valid` with `resp_kind` = 1 and the filled word. A later read of the same address hits.
- R6: A line hits only when its stored tag equals the physical page returned by the translation. Two virtual pages mapped to one physical page share the line. Two physical pages with the same index evict each other.
- R7: A permitted write with a translation hit sets the entry's dirty bit (`resp_flags[0]`). On a line hit it stores the write data. On a line miss it fetches the line, then stores the write data in place of the returned word. In both cases `resp_rdata` shows the written word.
- R8: A write to a page whose write-permission bit is 0 responds with `resp_kind` = 3. It issues no memory request, leaves the stored word unchanged and does not set the dirty bit.
- R9: Entries written through the refill port replace slots in strict rotation starting at slot 0. After eight installs, a ninth install evicts the first one, and the other entries stay usable.
- R10: A request presented while `busy` is high is ignored: it produces no response and no memory or refill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | Waiting for a memory response |
| resp_valid | output | 1 | Response strobe |
| resp_kind | output | 2 | 0 hit, 1 filled after miss, 2 translation miss, 3 protection fault |
| resp_rdata | output | 32 | Read word, or written word for writes |
| resp_flags | output | 2 | [1] referenced, [0] dirty of the entry after the access |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_paddr | output | 32 | Physical address of the memory read |
| mem_resp_valid | input | 1 | Memory read data strobe |
| mem_resp_data | input | 32 | Memory read word |
| tlb_refill_req | output | 1 | Translation refill request pulse |
| tlb_refill_vpn | output | 20 | Virtual page needing a translation |
| tlb_wr_en | input | 1 | Install a translation entry |
| tlb_wr_vpn | input | 20 | Virtual page of the new entry |
| tlb_wr_ppn | input | 20 | Physical page of the new entry |
| tlb_wr_allow_w | input | 1 | Write permission of the new entry |

## Verification
Lookups are run with every combination of translation result and line result. Two virtual pages that alias one physical page show that the hit decision is made on the physical tag rather than the virtual one. Two physical pages with the same page offset show that a line is evicted when it should be. Write patterns cover a write hit, a write that allocates a line on a miss, and a write refused for lack of permission. Read-backs afterwards show whether the stored word or the dirty flag was disturbed. A ninth install shows which slot the rotation replaces.

// File: rtl/lk_pkg.sv
package lk_pkg;
    typedef enum logic [1:0] {
        K_HIT   = 2'd0,
        K_FILL  = 2'd1,
        K_TMISS = 2'd2,
        K_FAULT = 2'd3
    } lk_kind_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } lk_state_e;
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int TLB_N = 8,
    localparam int SEL_W = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [SEL_W-1:0] hit_sel,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_allow_w,
    output logic             hit_ref,
    output logic             hit_dirty,
    input  logic             upd_en,
    input  logic [SEL_W-1:0] upd_sel,
    input  logic             upd_dirty,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_allow_w
);
    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             refd;
        logic             dirty;
        logic             allow_w;
    } ent_t;

    ent_t             ent_q [TLB_N];
    logic [SEL_W-1:0] rot_q;

    // rotating replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n)
            rot_q <= '0;
        else if (wr_en)
            rot_q <= (rot_q == SEL_W'(TLB_N - 1)) ? '0 : rot_q + 1'b1;
    end

    // one register slice per entry; an install takes priority over a flag update
    for (genvar k = 0; k < TLB_N; k++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[k] <= '0;
            end else if (wr_en && rot_q == SEL_W'(k)) begin
                ent_q[k] <= '{v: 1'b1, vpn: wr_vpn, ppn: wr_ppn,
                              refd: 1'b0, dirty: 1'b0, allow_w: wr_allow_w};
            end else if (upd_en && upd_sel == SEL_W'(k)) begin
                ent_q[k].refd <= 1'b1;
                if (upd_dirty)
                    ent_q[k].dirty <= 1'b1;
            end
        end
    end

    // parallel match, lowest matching slot wins
    always_comb begin
        hit     = 1'b0;
        hit_sel = '0;
        for (int i = 0; i < TLB_N; i++) begin
            if (!hit && ent_q[i].v && ent_q[i].vpn == look_vpn) begin
                hit     = 1'b1;
                hit_sel = SEL_W'(i);
            end
        end
        hit_ppn     = ent_q[hit_sel].ppn;
        hit_allow_w = ent_q[hit_sel].allow_w;
        hit_ref     = ent_q[hit_sel].refd;
        hit_dirty   = ent_q[hit_sel].dirty;
    end
endmodule

// File: rtl/line_store.sv
module line_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/ovl_lookup.sv
module ovl_lookup
    import lk_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int OFF_W  = 2,
    parameter int PPN_W  = 20,
    parameter int DATA_W = 32,
    parameter int TLB_N  = 8,
    localparam int VPN_W = VA_W - PAGE_W,
    localparam int IDX_W = PAGE_W - OFF_W,
    localparam int PA_W  = PPN_W + PAGE_W,
    localparam int SEL_W = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [1:0]        resp_flags,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_paddr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data,
    output logic              tlb_refill_req,
    output logic [VPN_W-1:0]  tlb_refill_vpn,
    input  logic              tlb_wr_en,
    input  logic [VPN_W-1:0]  tlb_wr_vpn,
    input  logic [PPN_W-1:0]  tlb_wr_ppn,
    input  logic              tlb_wr_allow_w
);
    typedef struct packed {
        lk_state_e         st;
        logic              resp_v;
        lk_kind_e          kind;
        logic [DATA_W-1:0] rdata;
        logic [1:0]        flags;
        logic              mreq;
        logic [PA_W-1:0]   paddr;
        logic              rreq;
        logic [VPN_W-1:0]  rvpn;
        logic              pend_wr;
        logic [DATA_W-1:0] pend_wd;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // field split of the virtual address
    logic [VPN_W-1:0] va_vpn;
    logic [IDX_W-1:0] va_idx;
    assign va_vpn = req_vaddr[VA_W-1:PAGE_W];
    assign va_idx = req_vaddr[PAGE_W-1:OFF_W];

    // translation side
    logic             t_hit, t_allow_w, t_ref, t_dirty;
    logic [SEL_W-1:0] t_sel;
    logic [PPN_W-1:0] t_ppn;
    logic             upd_en, upd_dirty;

    xlat_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .TLB_N(TLB_N)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_vpn   (va_vpn),
        .hit        (t_hit),
        .hit_sel    (t_sel),
        .hit_ppn    (t_ppn),
        .hit_allow_w(t_allow_w),
        .hit_ref    (t_ref),
        .hit_dirty  (t_dirty),
        .upd_en     (upd_en),
        .upd_sel    (t_sel),
        .upd_dirty  (upd_dirty),
        .wr_en      (tlb_wr_en),
        .wr_vpn     (tlb_wr_vpn),
        .wr_ppn     (tlb_wr_ppn),
        .wr_allow_w (tlb_wr_allow_w)
    );

    // data side, indexed by untranslated offset bits in the same cycle
    logic              c_valid;
    logic [PPN_W-1:0]  c_tag;
    logic [DATA_W-1:0] c_data;
    logic              c_wr;
    logic [IDX_W-1:0]  c_wr_idx;
    logic [PPN_W-1:0]  c_wr_tag;
    logic [DATA_W-1:0] c_wr_data;

    line_store #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (va_idx),
        .rd_valid(c_valid),
        .rd_tag  (c_tag),
        .rd_data (c_data),
        .wr_en   (c_wr),
        .wr_idx  (c_wr_idx),
        .wr_tag  (c_wr_tag),
        .wr_data (c_wr_data)
    );

    logic line_match;
    assign line_match = c_valid && (c_tag == t_ppn);

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.resp_v = 1'b0;
        ctl_d.mreq   = 1'b0;
        ctl_d.rreq   = 1'b0;
        upd_en       = 1'b0;
        upd_dirty    = 1'b0;
        c_wr         = 1'b0;
        c_wr_idx     = va_idx;
        c_wr_tag     = t_ppn;
        c_wr_data    = req_wdata;

        unique case (ctl_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (!t_hit) begin
                        ctl_d.resp_v = 1'b1;
                        ctl_d.kind   = K_TMISS;
                        ctl_d.rdata  = '0;
                        ctl_d.flags  = 2'b00;
                        ctl_d.rreq   = 1'b1;
                        ctl_d.rvpn   = va_vpn;
                    end else if (req_write && !t_allow_w) begin
                        ctl_d.resp_v = 1'b1;
                        ctl_d.kind   = K_FAULT;
                        ctl_d.rdata  = '0;
                        ctl_d.flags  = {t_ref, t_dirty};
                    end else begin
                        upd_en      = 1'b1;
                        upd_dirty   = req_write;
                        ctl_d.flags = {1'b1, t_dirty | req_write};
                        if (line_match) begin
                            ctl_d.resp_v = 1'b1;
                            ctl_d.kind   = K_HIT;
                            ctl_d.rdata  = req_write ? req_wdata : c_data;
                            c_wr         = req_write;
                        end else begin
                            ctl_d.mreq    = 1'b1;
                            ctl_d.paddr   = {t_ppn, req_vaddr[PAGE_W-1:0]};
                            ctl_d.pend_wr = req_write;
                            ctl_d.pend_wd = req_wdata;
                            ctl_d.st      = S_WAIT;
                        end
                    end
                end
            end
            S_WAIT: begin
                if (mem_resp_valid) begin
                    c_wr         = 1'b1;
                    c_wr_idx     = ctl_q.paddr[PAGE_W-1:OFF_W];
                    c_wr_tag     = ctl_q.paddr[PA_W-1:PAGE_W];
                    c_wr_data    = ctl_q.pend_wr ? ctl_q.pend_wd : mem_resp_data;
                    ctl_d.resp_v = 1'b1;
                    ctl_d.kind   = K_FILL;
                    ctl_d.rdata  = c_wr_data;
                    ctl_d.st     = S_IDLE;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, kind: K_HIT, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy           = (ctl_q.st == S_WAIT);
    assign resp_valid     = ctl_q.resp_v;
    assign resp_kind      = ctl_q.kind;
    assign resp_rdata     = ctl_q.rdata;
    assign resp_flags     = ctl_q.flags;
    assign mem_req_valid  = ctl_q.mreq;
    assign mem_req_paddr  = ctl_q.paddr;
    assign tlb_refill_req = ctl_q.rreq;
    assign tlb_refill_vpn = ctl_q.rvpn;
endmodule

// File: rtl/ovl_lookup_chk.sv
module ovl_lookup_chk #(
    parameter int VA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int PA_W   = 32,
    parameter int VPN_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             busy,
    input logic             resp_valid,
    input logic [1:0]       resp_kind,
    input logic [1:0]       resp_flags,
    input logic             mem_req_valid,
    input logic [PA_W-1:0]  mem_req_paddr,
    input logic             mem_resp_valid,
    input logic             tlb_refill_req
);
    // R2
    refill_has_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_refill_req |-> (resp_valid && resp_kind == 2'd2));

    // R4
    mem_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R4
    mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R4
    mem_req_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_paddr[PAGE_W-1:0] == $past(req_vaddr[PAGE_W-1:0])));

    // R3
    hit_sets_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'd0) |-> resp_flags[1]);

    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'd3) |-> (!mem_req_valid && !tlb_refill_req && !resp_flags[0]));

    // R10
    busy_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_resp_valid) |=> !resp_valid);
endmodule

bind ovl_lookup ovl_lookup_chk #(
    .VA_W(VA_W), .PAGE_W(PAGE_W), .PA_W(PA_W), .VPN_W(VPN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .busy          (busy),
    .resp_valid    (resp_valid),
    .resp_kind     (resp_kind),
    .resp_flags    (resp_flags),
    .mem_req_valid (mem_req_valid),
    .mem_req_paddr (mem_req_paddr),
    .mem_resp_valid(mem_resp_valid),
    .tlb_refill_req(tlb_refill_req)
);

// File: tb/ovl_lookup_tb.sv
module ovl_lookup_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0, req_wdata = '0;
    logic        busy, resp_valid, mem_req_valid, tlb_refill_req;
    logic [1:0]  resp_kind, resp_flags;
    logic [31:0] resp_rdata, mem_req_paddr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic [19:0] tlb_refill_vpn;
    logic        tlb_wr_en = 1'b0, tlb_wr_allow_w = 1'b0;
    logic [19:0] tlb_wr_vpn = '0, tlb_wr_ppn = '0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovl_lookup u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .busy(busy), .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_rdata(resp_rdata),
        .resp_flags(resp_flags), .mem_req_valid(mem_req_valid), .mem_req_paddr(mem_req_paddr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .tlb_refill_req(tlb_refill_req), .tlb_refill_vpn(tlb_refill_vpn),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
        .tlb_wr_allow_w(tlb_wr_allow_w)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // presents one request for one edge; returns at the following falling edge
    task automatic lookup(input logic wr, input logic [31:0] va, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic install(input logic [19:0] vpn, input logic [19:0] ppn, input logic aw);
        @(negedge clk);
        tlb_wr_en = 1'b1; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn; tlb_wr_allow_w = aw;
        @(posedge clk);
        @(negedge clk);
        tlb_wr_en = 1'b0;
    endtask

    // called at a falling edge while busy; returns when the fill response is visible
    task automatic mem_reply(input logic [31:0] d);
        mem_resp_valid = 1'b1; mem_resp_data = d;
        @(posedge clk);
        @(negedge clk);
        mem_resp_valid = 1'b0;
    endtask

    task automatic expect_resp(input string rq, input logic [1:0] kind, input logic [31:0] d,
                               input logic [1:0] fl);
        chk({rq, " resp_valid"}, resp_valid, 1'b1);
        chk({rq, " kind"}, resp_kind, kind);
        chk({rq, " rdata"}, resp_rdata, d);
        chk({rq, " flags"}, resp_flags, fl);
    endtask

    task automatic expect_memreq(input string rq, input logic [31:0] pa);
        chk({rq, " no resp yet"}, resp_valid, 1'b0);
        chk({rq, " mem_req"}, mem_req_valid, 1'b1);
        chk({rq, " paddr"}, mem_req_paddr, pa);
        chk({rq, " busy"}, busy, 1'b1);
    endtask

    task automatic t_reset();
        // R1
        chk("R1 busy", busy, 1'b0);
        chk("R1 resp_valid", resp_valid, 1'b0);
        chk("R1 mem_req", mem_req_valid, 1'b0);
        chk("R1 refill_req", tlb_refill_req, 1'b0);
        // R2: empty buffer gives a translation miss
        lookup(1'b0, 32'h1234_5678, '0);
        expect_resp("R1 R2 first lookup", 2'd2, 32'h0, 2'b00);
        chk("R2 refill_req", tlb_refill_req, 1'b1);
        chk("R2 refill_vpn", tlb_refill_vpn, 20'h12345);
        chk("R2 no mem_req", mem_req_valid, 1'b0);
        @(negedge clk);
        chk("R2 refill pulse ends", tlb_refill_req, 1'b0);
    endtask

    task automatic t_miss_fill();
        install(20'h12345, 20'h00ABC, 1'b1);
        lookup(1'b0, 32'h1234_5678, '0);
        expect_memreq("R4 read miss", 32'h00AB_C678);
        // R10: a request while busy must be ignored
        lookup(1'b0, 32'h1234_5000, '0);
        chk("R4 single mem_req pulse", mem_req_valid, 1'b0);
        chk("R10 ignored no resp", resp_valid, 1'b0);
        chk("R10 ignored no refill", tlb_refill_req, 1'b0);
        chk("R10 still busy", busy, 1'b1);
        mem_reply(32'hDEAD_BEEF);
        expect_resp("R5 fill", 2'd1, 32'hDEAD_BEEF, 2'b10);
        chk("R5 not busy", busy, 1'b0);
    endtask

    task automatic t_read_hit();
        lookup(1'b0, 32'h1234_5678, '0);
        expect_resp("R3 R5 read hit", 2'd0, 32'hDEAD_BEEF, 2'b10);
        chk("R3 no mem_req", mem_req_valid, 1'b0);
    endtask

    task automatic t_physical_tag();
        install(20'h55555, 20'h00ABC, 1'b1);
        lookup(1'b0, 32'h5555_5678, '0);
        expect_resp("R6 synonym hit", 2'd0, 32'hDEAD_BEEF, 2'b10);
        install(20'h66666, 20'h00DEF, 1'b1);
        lookup(1'b0, 32'h6666_6678, '0);
        expect_memreq("R6 same index other page", 32'h00DE_F678);
        mem_reply(32'h1111_2222);
        expect_resp("R6 fill other page", 2'd1, 32'h1111_2222, 2'b10);
        lookup(1'b0, 32'h1234_5678, '0);
        expect_memreq("R6 evicted line", 32'h00AB_C678);
        mem_reply(32'hDEAD_BEEF);
        expect_resp("R6 refill", 2'd1, 32'hDEAD_BEEF, 2'b10);
    endtask

    task automatic t_write();
        lookup(1'b1, 32'h1234_5678, 32'hCAFE_F00D);
        expect_resp("R7 write hit", 2'd0, 32'hCAFE_F00D, 2'b11);
        lookup(1'b0, 32'h5555_5678, '0);
        expect_resp("R7 read back via alias", 2'd0, 32'hCAFE_F00D, 2'b10);
        lookup(1'b1, 32'h6666_6678, 32'h0BAD_F00D);
        expect_memreq("R7 write miss", 32'h00DE_F678);
        mem_reply(32'h9999_9999);
        expect_resp("R7 write allocate", 2'd1, 32'h0BAD_F00D, 2'b11);
        lookup(1'b0, 32'h6666_6678, '0);
        expect_resp("R7 read after allocate", 2'd0, 32'h0BAD_F00D, 2'b11);
    endtask

    task automatic t_fault();
        install(20'h77777, 20'h00ABC, 1'b0);
        lookup(1'b0, 32'h7777_7010, '0);
        expect_memreq("R8 setup read miss", 32'h00AB_C010);
        mem_reply(32'h0102_0304);
        expect_resp("R8 setup fill", 2'd1, 32'h0102_0304, 2'b10);
        lookup(1'b1, 32'h7777_7010, 32'hFFFF_FFFF);
        expect_resp("R8 protection fault", 2'd3, 32'h0, 2'b10);
        chk("R8 no mem_req", mem_req_valid, 1'b0);
        lookup(1'b0, 32'h7777_7010, '0);
        expect_resp("R8 word unchanged", 2'd0, 32'h0102_0304, 2'b10);
    endtask

    task automatic t_rotation();
        for (int i = 1; i <= 4; i++)
            install(20'h80000 + 20'(i), 20'h00100 + 20'(i), 1'b1);
        install(20'h90000, 20'h00200, 1'b1);
        lookup(1'b0, 32'h1234_5678, '0);
        expect_resp("R9 slot 0 replaced", 2'd2, 32'h0, 2'b00);
        chk("R9 refill vpn", tlb_refill_vpn, 20'h12345);
        lookup(1'b0, 32'h5555_5010, '0);
        expect_resp("R9 slot 1 kept", 2'd0, 32'h0102_0304, 2'b10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_fill();
        t_read_hit();
        t_physical_tag();
        t_write();
        t_fault();
        t_rotation();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule